// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Scheduler

This block times the power switch of a critical-conduction, constant on-time converter. A single period counter starts from zero each time the gate request goes high. It serves two purposes. During the on-time it limits how long the switch stays on. After the switch opens it decides which event starts the next cycle. Those events are a valley pulse from the ringing detector, a fallback deadline for the case where ringing was seen only early in the period, and a long starter timeout.

Turn-off comes from the on-time comparator, the peak-current comparator, or a hard on-time ceiling. A leading-edge window masks both comparators just after turn-on. A minimum on-time, given as a live input because it follows the line voltage, further masks the on-time comparator. A protection enable forces the gate request low in the same cycle and clears all timing. After enable returns, only the starter may begin the first cycle. All durations are parameters counted in clock cycles.

Top module: `qr_cycle_sched`

## Requirements
- R1: After reset with enable high and any valley input, the gate request stays low and first rises START_CYC clock edges after the first edge that samples enable high.
- R2: While enable is low the gate request is low in that same cycle, and the period count is zero.
- R3: The period count p is the number of edges since the edge that raised the gate, so p is 0 in the first high cycle. A valley pulse sampled with p < BLANK_CYC never starts a cycle, and neither does a valley that arrives while the gate is high.
- R4: With the gate low and p >= BLANK_CYC, a valley pulse raises the gate on the next edge. The period between rises is then p+1 cycles.
- R5: If a valley was sampled with p < BLANK_CYC and none follows, the gate rises on the edge that samples p = BLANK_CYC+EXTRA_CYC. That gives a period of BLANK_CYC+EXTRA_CYC+1 cycles.
- R6: With no qualifying valley, the gate rises on the edge that samples p = START_CYC. That gives a period of START_CYC+1 cycles.
- R7: The gate stays high for at most MAXON_CYC cycles. With no trip it falls after exactly MAXON_CYC cycles.
- R8: A current-limit trip sampled at p >= LEB_CYC lowers the gate on that edge, whatever the minimum on-time is.
- R9: An on-time trip lowers the gate only when it is sampled with p >= LEB_CYC and p >= min_on_cycles. A steady trip therefore gives max(LEB_CYC, min_on_cycles)+1 high cycles.
- R10: Trips sampled with p < LEB_CYC are ignored.
- R11: After enable is lowered and raised again, valleys are ignored until the starter fires, START_CYC edges after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Protection enable, low forces gate off and clears timing |
| valley_pulse | input | 1 | One-cycle pulse near a drain-voltage valley |
| ton_trip | input | 1 | On-time comparator output, high ends the on-time |
| ilim_trip | input | 1 | Peak-current comparator output, high ends the on-time |
| min_on_cycles | input | MINON_W | Minimum on-time in cycles, set by line voltage |
| gate_req | output | 1 | Gate-drive request |

## Verification
Every decision is registered once, so a valley, trip or deadline sampled at one edge changes gate_req right after that edge. A low enable is the exception and clears gate_req combinationally within the same cycle. The bench drives inputs at the falling edge, advances a requirement-level model across the next rising edge, and compares gate_req two nanoseconds after that edge; it also checks the same-cycle enable effect one nanosecond after driving. Directed periods then compare measured high-time and rise-to-rise spacing against the formulas in R4 to R9.

// File: rtl/qr_sched_pkg.sv
package qr_sched_pkg;

   // origin of a new switching cycle
   typedef enum logic [1:0] {
      SRC_NONE     = 2'd0,
      SRC_VALLEY   = 2'd1,
      SRC_FALLBACK = 2'd2,
      SRC_STARTER  = 2'd3
   } start_src_e;

endpackage

// File: rtl/qr_period_timer.sv
module qr_period_timer #(
   parameter int CW    = 14,
   parameter int LIMIT = 13000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          restart,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || restart) begin
         cnt <= '0;
      end else if (cnt != LIMIT_C) begin
         cnt <= cnt + 1'b1;
      end
   end

   // saturation keeps the count within its limit
   sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT_C);

endmodule

// File: rtl/qr_on_limiter.sv
module qr_on_limiter #(
   parameter int CW        = 14,
   parameter int MW        = 13,
   parameter int MAXON_CYC = 4700,
   parameter int LEB_CYC   = 40
) (
   input  logic          gate_on,
   input  logic [CW-1:0] cnt,
   input  logic          ton_trip,
   input  logic          ilim_trip,
   input  logic [MW-1:0] min_on,
   output logic          end_on
);

   localparam int XW = (CW > MW) ? CW : MW;
   localparam logic [CW-1:0] LAST_C = CW'(MAXON_CYC - 1);

   logic [XW-1:0] cnt_x;
   logic [XW-1:0] min_x;
   logic          leb_done;
   logic          min_done;

   assign cnt_x    = XW'(cnt);
   assign min_x    = XW'(min_on);
   assign min_done = (cnt_x >= min_x);

   generate
      if (LEB_CYC == 0) begin : g_no_leb
         assign leb_done = 1'b1;
      end else begin : g_leb
         localparam logic [CW-1:0] LEB_C = CW'(LEB_CYC);
         assign leb_done = (cnt >= LEB_C);
      end
   endgenerate

   always_comb begin
      end_on = 1'b0;
      if (gate_on) begin
         if (cnt == LAST_C)
            end_on = 1'b1;
         else if (leb_done && ilim_trip)
            end_on = 1'b1;
         else if (leb_done && min_done && ton_trip)
            end_on = 1'b1;
      end
   end

endmodule

// File: rtl/qr_start_arbiter.sv
module qr_start_arbiter
   import qr_sched_pkg::*;
#(
   parameter int CW          = 14,
   parameter int BLANK_CYC   = 850,
   parameter int EXTRA_CYC   = 500,
   parameter int START_CYC   = 13000,
   parameter bit FALLBACK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          gate_on,
   input  logic          valley,
   input  logic [CW-1:0] cnt,
   output start_src_e    src
);

   localparam logic [CW-1:0] BLANK_C = CW'(BLANK_CYC);
   localparam logic [CW-1:0] START_C = CW'(START_CYC);

   logic       seen_q;
   logic       restart_q;
   logic       fb_hit;
   logic       in_blank;
   logic       starting;

   assign in_blank = (cnt < BLANK_C);
   assign starting = (src != SRC_NONE);

   generate
      if (FALLBACK_EN) begin : g_fb
         localparam logic [CW-1:0] FB_C = CW'(BLANK_CYC + EXTRA_CYC);
         assign fb_hit = seen_q && (cnt == FB_C);
      end else begin : g_no_fb
         assign fb_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      src = SRC_NONE;
      if (enable && !gate_on) begin
         if (cnt == START_C)
            src = SRC_STARTER;
         else if (!restart_q && valley && !in_blank)
            src = SRC_VALLEY;
         else if (!restart_q && fb_hit)
            src = SRC_FALLBACK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         restart_q <= 1'b1;
      end else if (!enable) begin
         seen_q    <= 1'b0;
         restart_q <= 1'b1;
      end else if (starting) begin
         seen_q    <= 1'b0;
         restart_q <= 1'b0;
      end else if (valley && in_blank) begin
         seen_q    <= 1'b1;
      end
   end

   // R11
   restart_only_starter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_q && starting) |-> (cnt == START_C));

endmodule

// File: rtl/qr_cycle_sched.sv
module qr_cycle_sched
   import qr_sched_pkg::*;
#(
   parameter int BLANK_CYC   = 850,
   parameter int EXTRA_CYC   = 500,
   parameter int START_CYC   = 13000,
   parameter int MAXON_CYC   = 4700,
   parameter int LEB_CYC     = 40,
   parameter int MINON_W     = 13,
   parameter bit FALLBACK_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               valley_pulse,
   input  logic               ton_trip,
   input  logic               ilim_trip,
   input  logic [MINON_W-1:0] min_on_cycles,
   output logic               gate_req
);

   localparam int CW = $clog2(START_CYC + 1);
   localparam logic [CW-1:0] BLANK_C = CW'(BLANK_CYC);
   localparam logic [CW-1:0] START_C = CW'(START_CYC);
   localparam logic [CW-1:0] MAXON_C = CW'(MAXON_CYC);
   localparam logic [CW-1:0] LEB_C   = CW'(LEB_CYC);

   generate
      if (START_CYC <= BLANK_CYC + EXTRA_CYC) begin : g_bad_start
         $error("starter timeout must exceed blank plus fallback delay");
      end
      if (MAXON_CYC <= LEB_CYC) begin : g_bad_maxon
         $error("maximum on-time must exceed leading-edge blank");
      end
      if (MAXON_CYC >= START_CYC) begin : g_bad_period
         $error("maximum on-time must be shorter than starter timeout");
      end
      if (BLANK_CYC < 1 || MINON_W < 1) begin : g_bad_misc
         $error("blank and minimum on-time width must be nonzero");
      end
   endgenerate

   logic          gate_q;
   logic [CW-1:0] cnt;
   logic          end_on;
   start_src_e    src;
   logic          start_now;

   assign start_now = (src != SRC_NONE);

   qr_period_timer #(
      .CW    (CW),
      .LIMIT (START_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!enable),
      .restart (start_now),
      .cnt     (cnt)
   );

   qr_start_arbiter #(
      .CW          (CW),
      .BLANK_CYC   (BLANK_CYC),
      .EXTRA_CYC   (EXTRA_CYC),
      .START_CYC   (START_CYC),
      .FALLBACK_EN (FALLBACK_EN)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .gate_on (gate_q),
      .valley  (valley_pulse),
      .cnt     (cnt),
      .src     (src)
   );

   qr_on_limiter #(
      .CW        (CW),
      .MW        (MINON_W),
      .MAXON_CYC (MAXON_CYC),
      .LEB_CYC   (LEB_CYC)
   ) u_lim (
      .gate_on   (gate_q),
      .cnt       (cnt),
      .ton_trip  (ton_trip),
      .ilim_trip (ilim_trip),
      .min_on    (min_on_cycles),
      .end_on    (end_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gate_q <= 1'b0;
      else if (!enable)
         gate_q <= 1'b0;
      else if (start_now)
         gate_q <= 1'b1;
      else if (end_on)
         gate_q <= 1'b0;
   end

   assign gate_req = gate_q && enable;

   // R2
   disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!gate_q && cnt == '0));

   // R3
   min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> ($past(cnt) >= BLANK_C));

   // R6
   starter_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !gate_q && cnt == START_C) |=> gate_q);

   // R7
   max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q |-> (cnt < MAXON_C));

   // R8
   ilim_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q && enable && ilim_trip && cnt >= LEB_C) |=> !gate_q);

   // R10
   leb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q && enable && cnt < LEB_C) |=> gate_q);

endmodule

// File: tb/qr_cycle_sched_test.sv
`timescale 1ns/1ps
module qr_cycle_sched_test;

   localparam int BLANK = 40;
   localparam int EXTRA = 20;
   localparam int START = 300;
   localparam int MAXON = 60;
   localparam int LEB   = 4;
   localparam int MW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          valley_pulse = 1'b0;
   logic          ton_trip = 1'b0;
   logic          ilim_trip = 1'b0;
   logic [MW-1:0] min_on_cycles = '0;
   logic          gate_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // requirement-level model state
   bit    m_gate;
   int    m_cnt;
   bit    m_seen;
   bit    m_restart;
   string m_tag;

   always #5 clk = ~clk;

   qr_cycle_sched #(
      .BLANK_CYC (BLANK),
      .EXTRA_CYC (EXTRA),
      .START_CYC (START),
      .MAXON_CYC (MAXON),
      .LEB_CYC   (LEB),
      .MINON_W   (MW)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .valley_pulse  (valley_pulse),
      .ton_trip      (ton_trip),
      .ilim_trip     (ilim_trip),
      .min_on_cycles (min_on_cycles),
      .gate_req      (gate_req)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int sat(input int v);
      return (v > START) ? START : v;
   endfunction

   // advance the model across one rising edge with the given inputs
   task automatic model_edge(input bit en, v, t, i, input int mo);
      int p;
      p = m_cnt;
      if (!en) begin
         m_gate = 0; m_cnt = 0; m_seen = 0; m_restart = 1; m_tag = "R2";
      end else if (m_gate) begin
         m_tag = (p < LEB) ? "R10" : "R9";
         if (p == MAXON - 1) begin
            m_gate = 0; m_tag = "R7";
         end else if (i && p >= LEB) begin
            m_gate = 0; m_tag = "R8";
         end else if (t && p >= LEB && p >= mo) begin
            m_gate = 0; m_tag = "R9";
         end
         if (v && p < BLANK) m_seen = 1;
         m_cnt = sat(p + 1);
      end else begin
         bit st;
         st = 0; m_tag = "R3";
         if (p == START) begin
            st = 1; m_tag = m_restart ? "R11" : "R6";
         end else if (!m_restart && v && p >= BLANK) begin
            st = 1; m_tag = "R4";
         end else if (!m_restart && m_seen && p == BLANK + EXTRA) begin
            st = 1; m_tag = "R5";
         end
         if (st) begin
            m_gate = 1; m_cnt = 0; m_seen = 0; m_restart = 0;
         end else begin
            if (v && p < BLANK) m_seen = 1;
            m_cnt = sat(p + 1);
         end
      end
   endtask

   task automatic step(input bit en, v, t, i, input int mo);
      @(negedge clk);
      enable = en; valley_pulse = v; ton_trip = t; ilim_trip = i;
      min_on_cycles = MW'(mo);
      #1;
      if (!en) check(gate_req == 1'b0, "R2 same-cycle", int'(gate_req), 0);
      model_edge(en, v, t, i, mo);
      @(posedge clk);
      #2;
      check(gate_req == (m_gate && en), m_tag, int'(gate_req), int'(m_gate && en));
   endtask

   // runs one period after an observed rise; returns high time and rise spacing
   task automatic run_period(input int va, vb, ton_at, ilim_a, ilim_b, mo,
                             output int on_len, output int per_len);
      bit fell;
      fell = 0; on_len = -1; per_len = -1;
      for (int j = 1; j <= START + 5; j++) begin
         int p;
         p = j - 1;
         step(1'b1, (p == va) || (p == vb), (ton_at >= 0) && (p >= ton_at),
              (p == ilim_a) || (p == ilim_b), mo);
         if (!fell && !gate_req) begin
            fell = 1; on_len = j;
         end else if (fell && gate_req) begin
            per_len = j;
            break;
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int on_len, per_len, first;
      m_gate = 0; m_cnt = 0; m_seen = 0; m_restart = 1; m_tag = "R1";
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #2;
      check(gate_req == 1'b0, "R1 reset", int'(gate_req), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: first cycle from starter, valleys ignored meanwhile
      first = -1;
      for (int k = 0; k <= START + 2; k++) begin
         step(1'b1, (k == BLANK + 2) || (k == 5), 1'b0, 1'b0, 0);
         if (gate_req && first < 0) first = k;
         if (first >= 0) break;
      end
      check(first == START, "R1 first rise", first, START);

      // R9 steady trip with min on-time 10; R4 valley after blank
      run_period(BLANK + 5, -1, 0, -1, -1, 10, on_len, per_len);
      check(on_len == 11, "R9 min on-time", on_len, 11);
      check(per_len == BLANK + 6, "R4 valley period", per_len, BLANK + 6);

      // R10 steady trip, no min on; R5 valley only in blank
      run_period(20, -1, 0, -1, -1, 0, on_len, per_len);
      check(on_len == LEB + 1, "R10 blanked trip", on_len, LEB + 1);
      check(per_len == BLANK + EXTRA + 1, "R5 fallback period", per_len, BLANK + EXTRA + 1);

      // R8 current limit in LEB ignored, later honoured despite min on; R4 after seen
      run_period(20, BLANK + 3, -1, 2, 7, 30, on_len, per_len);
      check(on_len == 8, "R8 current limit", on_len, 8);
      check(per_len == BLANK + 4, "R4 valley after seen", per_len, BLANK + 4);

      // R7 no trip; valley while gate high past blank is ignored (R3); starter R6
      run_period(BLANK + 5, -1, -1, -1, -1, 0, on_len, per_len);
      check(on_len == MAXON, "R7 max on-time", on_len, MAXON);
      check(per_len == START + 1, "R6 starter period", per_len, START + 1);

      // R3 valley at last blank cycle only -> fallback, not a valley start
      run_period(BLANK - 1, -1, 0, -1, -1, 0, on_len, per_len);
      check(per_len == BLANK + EXTRA + 1, "R3 blank edge", per_len, BLANK + EXTRA + 1);

      // R2 drop enable mid on-time, then R11 re-enable ignores valleys
      step(1'b1, 1'b0, 1'b0, 1'b0, 0);
      step(1'b0, 1'b0, 1'b0, 1'b0, 0);
      step(1'b0, 1'b1, 1'b0, 1'b0, 0);
      first = -1;
      for (int k = 0; k <= START + 2; k++) begin
         step(1'b1, (k == BLANK + 1) || (k == BLANK + EXTRA), 1'b0, 1'b0, 0);
         if (gate_req && first < 0) first = k;
         if (first >= 0) break;
      end
      check(first == START, "R11 restart via starter", first, START);

      // constrained random phase checked cycle by cycle against the model
      for (int k = 0; k < 20000; k++) begin
         bit en, v, t, i;
         int mo;
         en = ($urandom_range(0, 999) != 0) || !enable ? ($urandom_range(0, 3) != 0) : 1'b0;
         if (enable && $urandom_range(0, 999) != 0) en = 1'b1;
         v  = ($urandom_range(0, 24) == 0);
         t  = ($urandom_range(0, 5) == 0);
         i  = ($urandom_range(0, 40) == 0);
         mo = $urandom_range(0, 20);
         step(en, v, t, i, mo);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule